// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This controller-side block brings a DDR DRAM from power-on to a usable state. After reset it holds the clock enable low and waits for a configurable number of cycles. The cycle count is set to match the required 200 µs settling time. It then raises the clock enable and issues a fixed series of commands on the chip-select, row-strobe, column-strobe and write-enable pins, together with the matching address and bank-address values.

The series of commands is as follows:
- a precharge of all banks;
- an extended-mode write that enables the DLL;
- a mode write that resets the DLL;
- a second precharge of all banks;
- a configurable number of auto refreshes;
- a final mode write that loads the operating mode.

After every command the block spends a programmable number of cycles on NOP. The precharge gap, the refresh gap and the mode-write gap are inputs given in clock cycles.

A separate lock timer starts when the DLL reset is issued. The ready flag rises only when two conditions hold: the final mode-write gap has elapsed, and the lock timer has counted the DLL lock time. From then on the block holds NOP with the clock enable high, and the memory controller may take over the pins.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for the first PWRUP_CYC cycles after reset falls (cycles 0 to PWRUP_CYC-1), `cke` is 0, `done` is 0, the command is NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), and `addr` and `ba` are 0.
- R2: In cycle PWRUP_CYC the block drives NOP with `cke` 1. From then on `cke` never returns to 0 until the next reset.
- R3: A precharge-all is encoded as 4'b0010, with `addr` bit 10 set, every other address bit 0, and `ba`=0. The first precharge-all is issued in cycle PWRUP_CYC+1.
- R4: Each command is followed by NOP for exactly its gap in cycles. The gap is `t_rp` after a precharge, `t_mrd` after any mode write, and `t_rfc` after a refresh. A gap input of 0 is treated as 1.
- R5: The extended-mode write is encoded as 4'b0000, with `ba`=2'b01 and `addr`=0. Address bit 0 low means the DLL is enabled.
- R6: The DLL-reset mode write is encoded as 4'b0000, with `ba`=2'b00 and `addr` equal to `mode_word` with bit 8 forced to 1.
- R7: Commands are issued in this order and no other: precharge-all, extended-mode write, DLL-reset mode write, precharge-all, REFRESH_CNT refreshes, final mode write.
- R8: An auto refresh is encoded as 4'b0001, with `addr`=0 and `ba`=0. With the default setting, exactly two refreshes are issued.
- R9: The final mode write is encoded as 4'b0000, with `ba`=2'b00 and `addr` equal to `mode_word` with bit 8 forced to 0.
- R10: `done` first goes to 1 in a cycle set by two earlier events: the final mode write (cycle F) and the DLL-reset write (cycle D). That cycle is the later of F+gap+1 and D+DLL_LOCK_CYC. From then on `done` stays 1, and the pins stay at NOP with `cke` 1.
- R11: Every cycle that carries no sequence command shows NOP with `addr`=0 and `ba`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| t_rp | input | 8 | Precharge gap in cycles (0 acts as 1) |
| t_rfc | input | 8 | Refresh gap in cycles (0 acts as 1) |
| t_mrd | input | 8 | Mode-write gap in cycles (0 acts as 1) |
| mode_word | input | 12 | Operating mode value for the mode-register writes |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address pins |
| done | output | 1 | High once the DRAM is ready for normal traffic |

## Verification
The two functions that can meet in one cycle are the expiry of the last mode-write gap and the expiry of the independent DLL lock timer. Each of them can decide the cycle in which `done` rises. The bench sweeps all combinations of the three gap inputs from 0 to 8 with a short lock time. The distance from the DLL reset to the end of the final gap, 2·t_mrd+t_rp+2·t_rfc+5, therefore lands below, on and above the lock time. In every run, the ready cycle is predicted as the maximum of the two terms and compared cycle by cycle with the full pin trace.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    parameter int ADDR_W      = 12;
    parameter int BA_W        = 2;
    parameter int TW          = 8;
    parameter int AP_BIT      = 10;
    parameter int DLL_RST_BIT = 8;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_CKE,
        ST_PRE1,
        ST_EMRS,
        ST_DLLRST,
        ST_PRE2,
        ST_REF,
        ST_MRS,
        ST_WAIT,
        ST_FIN
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } dram_cmd_t;

    typedef struct packed {
        dram_cmd_t             cmd;
        logic [BA_W-1:0]       ba;
        logic [ADDR_W-1:0]     addr;
        logic                  cke;
    } pin_bus_t;

    function automatic logic [TW-1:0] gap_of(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

endpackage

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int PWRUP_CYC   = 40000,
    parameter int REFRESH_CNT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_rfc,
    input  logic [TW-1:0] t_mrd,
    output seq_state_t    state_o
);
    localparam int PW    = $clog2(PWRUP_CYC + 1);
    localparam int CNT_W = (PW > TW) ? PW : TW;
    localparam int REF_W = $clog2(REFRESH_CNT + 1);

    seq_state_t        state_q, ret_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic [REF_W-1:0]  refs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PWR;
            ret_q   <= ST_PWR;
            wcnt_q  <= CNT_W'(PWRUP_CYC);
            refs_q  <= '0;
        end else begin
            case (state_q)
                ST_PWR: begin
                    if (wcnt_q <= CNT_W'(1)) state_q <= ST_CKE;
                    else                    wcnt_q  <= wcnt_q - 1'b1;
                end
                ST_CKE: state_q <= ST_PRE1;
                ST_PRE1: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= CNT_W'(gap_of(t_rp));
                    ret_q   <= ST_EMRS;
                end
                ST_EMRS: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= CNT_W'(gap_of(t_mrd));
                    ret_q   <= ST_DLLRST;
                end
                ST_DLLRST: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= CNT_W'(gap_of(t_mrd));
                    ret_q   <= ST_PRE2;
                end
                ST_PRE2: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= CNT_W'(gap_of(t_rp));
                    ret_q   <= ST_REF;
                end
                ST_REF: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= CNT_W'(gap_of(t_rfc));
                    refs_q  <= refs_q + 1'b1;
                    ret_q   <= (refs_q == REF_W'(REFRESH_CNT - 1)) ? ST_MRS : ST_REF;
                end
                ST_MRS: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= CNT_W'(gap_of(t_mrd));
                    ret_q   <= ST_FIN;
                end
                ST_WAIT: begin
                    if (wcnt_q <= CNT_W'(1)) state_q <= ret_q;
                    else                    wcnt_q  <= wcnt_q - 1'b1;
                end
                default: state_q <= ST_FIN;
            endcase
        end
    end

    assign state_o = state_q;

    // R7: a refresh is only ever followed (after its gap) by another refresh or the final mode write
    p_ref_order_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REF) |=> (ret_q == ST_REF || ret_q == ST_MRS));

    // R4: a gap always starts at a non-zero count
    p_gap_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_WAIT && $past(state_q) != ST_WAIT && state_q != ST_PWR) |-> (wcnt_q != '0));

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic locked
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if ((start && cnt_q == '0) ||
                     (cnt_q != '0 && cnt_q != LW'(LOCK_CYC))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign locked = (cnt_q == LW'(LOCK_CYC));

    // R10: once counted out, the lock indication never drops
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

endmodule

// File: rtl/ddr_init_pins.sv
module ddr_init_pins
    import ddr_init_pkg::*;
(
    input  seq_state_t          state,
    input  logic [ADDR_W-1:0]   mode_word,
    input  logic                locked,
    output pin_bus_t            pins,
    output logic                done
);
    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;

    always_comb begin
        pins.cmd  = CMD_NOP;
        pins.ba   = '0;
        pins.addr = '0;
        pins.cke  = (state != ST_PWR);
        case (state)
            ST_PRE1, ST_PRE2: begin
                pins.cmd  = CMD_PRE;
                pins.addr = AP_MASK;
            end
            ST_EMRS: begin
                pins.cmd = CMD_MRS;
                pins.ba  = BA_W'(1);
            end
            ST_DLLRST: begin
                pins.cmd  = CMD_MRS;
                pins.addr = mode_word | DLL_MASK;
            end
            ST_REF: pins.cmd = CMD_REF;
            ST_MRS: begin
                pins.cmd  = CMD_MRS;
                pins.addr = mode_word & ~DLL_MASK;
            end
            default: ;
        endcase
    end

    assign done = (state == ST_FIN) && locked;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int PWRUP_CYC    = 40000,
    parameter int DLL_LOCK_CYC = 200,
    parameter int REFRESH_CNT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        t_rp,
    input  logic [7:0]        t_rfc,
    input  logic [7:0]        t_mrd,
    input  logic [11:0]       mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [11:0]       addr,
    output logic              done
);
    seq_state_t state;
    pin_bus_t   pins;
    logic       locked;

    ddr_init_fsm #(
        .PWRUP_CYC  (PWRUP_CYC),
        .REFRESH_CNT(REFRESH_CNT)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .t_rp   (t_rp),
        .t_rfc  (t_rfc),
        .t_mrd  (t_mrd),
        .state_o(state)
    );

    ddr_init_lock #(
        .LOCK_CYC(DLL_LOCK_CYC)
    ) u_lock (
        .clk   (clk),
        .rst   (rst),
        .start (state == ST_DLLRST),
        .locked(locked)
    );

    ddr_init_pins u_pins (
        .state    (state),
        .mode_word(mode_word),
        .locked   (locked),
        .pins     (pins),
        .done     (done)
    );

    assign {cs_n, ras_n, cas_n, we_n} = pins.cmd;
    assign ba   = pins.ba;
    assign addr = pins.addr;
    assign cke  = pins.cke;

    // R2: clock enable never falls again once raised
    p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R1: no command other than NOP while clock enable is low
    p_cmd_needs_cke_r1: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |-> cke);

    // R4: every command is a single cycle and is followed by NOP
    p_cmd_then_nop_r4: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    // R10: ready is sticky and quiet
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP && cke));

    // R5: extended-mode write carries an all-zero address
    p_ext_write_r5: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MRS && ba[0]) |-> (addr == '0));

    // R3: precharge always targets all banks
    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == CMD_PRE) |-> addr[AP_BIT]);

endmodule

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
    localparam int P = 20;
    localparam int L = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  t_rp = 8'd1, t_rfc = 8'd1, t_mrd = 8'd1;
    logic [11:0] mode_word = '0;
    logic        cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]  ba;
    logic [11:0] addr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ddr_init_seq #(
        .PWRUP_CYC   (P),
        .DLL_LOCK_CYC(L),
        .REFRESH_CNT (2)
    ) u0 (
        .clk(clk), .rst(rst), .t_rp(t_rp), .t_rfc(t_rfc), .t_mrd(t_mrd),
        .mode_word(mode_word), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [19:0] pack(logic [3:0] c, logic [1:0] b,
                                         logic [11:0] a, logic k, logic d);
        return {c, b, a, k, d};
    endfunction

    task automatic check(string tag, logic [19:0] act, logic [19:0] exp, int t);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, t, act, exp);
        end
    endtask

    task automatic run_case(int m, int p, int f, logic [11:0] mw);
        int mm, pp, ff;
        int c_pre1, c_emrs, c_dll, c_pre2, c_ref0, c_ref1, c_mrs, c_done;
        logic [3:0] obs [0:15];
        logic [3:0] expseq [0:6];
        int n_obs;
        mm = (m == 0) ? 1 : m;
        pp = (p == 0) ? 1 : p;
        ff = (f == 0) ? 1 : f;
        c_pre1 = P + 1;
        c_emrs = c_pre1 + pp + 1;
        c_dll  = c_emrs + mm + 1;
        c_pre2 = c_dll + mm + 1;
        c_ref0 = c_pre2 + pp + 1;
        c_ref1 = c_ref0 + ff + 1;
        c_mrs  = c_ref1 + ff + 1;
        c_done = (c_mrs + mm + 1 > c_dll + L) ? c_mrs + mm + 1 : c_dll + L;
        expseq[0] = 4'b0010; expseq[1] = 4'b0000; expseq[2] = 4'b0000;
        expseq[3] = 4'b0010; expseq[4] = 4'b0001; expseq[5] = 4'b0001;
        expseq[6] = 4'b0000;
        n_obs = 0;

        @(negedge clk);
        rst = 1'b1;
        t_rp = 8'(p); t_rfc = 8'(f); t_mrd = 8'(m); mode_word = mw;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", pack({cs_n, ras_n, cas_n, we_n}, ba, addr, cke, done),
              pack(4'b0111, 2'b00, 12'h000, 1'b0, 1'b0), -1);
        rst = 1'b0;
        for (int t = 0; t <= c_done + 3; t++) begin
            logic [3:0]  ec;
            logic [1:0]  eb;
            logic [11:0] ea;
            string       tag;
            logic [3:0]  ac;
            ec = 4'b0111; eb = 2'b00; ea = 12'h000;
            if (t < P)            tag = "R1";
            else if (t == P)      tag = "R2";
            else if (t >= c_done) tag = "R10";
            else                  tag = "R4 R11";
            if (t == c_pre1 || t == c_pre2) begin
                ec = 4'b0010; ea = 12'h400; tag = "R3";
            end else if (t == c_emrs) begin
                ec = 4'b0000; eb = 2'b01; tag = "R5";
            end else if (t == c_dll) begin
                ec = 4'b0000; ea = mw | 12'h100; tag = "R6";
            end else if (t == c_ref0 || t == c_ref1) begin
                ec = 4'b0001; tag = "R8";
            end else if (t == c_mrs) begin
                ec = 4'b0000; ea = mw & ~12'h100; tag = "R9";
            end
            ac = {cs_n, ras_n, cas_n, we_n};
            if (ac != 4'b0111 && n_obs < 16) begin
                obs[n_obs] = ac;
                n_obs++;
            end
            check(tag, pack(ac, ba, addr, cke, done),
                  pack(ec, eb, ea, (t >= P) ? 1'b1 : 1'b0, (t >= c_done) ? 1'b1 : 1'b0), t);
            @(negedge clk);
        end
        // R7: command order
        begin
            logic ok;
            ok = (n_obs == 7);
            for (int i = 0; i < 7; i++)
                if (i < n_obs && obs[i] != expseq[i]) ok = 1'b0;
            checks++;
            if (!ok) begin
                failures++;
                $display("FAIL R7 order: actual count=%0d expected count=7 (m=%0d p=%0d f=%0d)",
                         n_obs, m, p, f);
            end
        end
    endtask

    initial begin
        for (int m = 0; m <= 8; m++)
            for (int p = 0; p <= 8; p++)
                for (int f = 0; f <= 8; f++)
                    run_case(m, p, f, 12'((m * 467 + p * 131 + f * 29 + 5) & 12'hFFF));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule